// File: doc/BRIEF.md
# Frame-Boundary Clipper Control Slave

This block is the memory-mapped control and status front end of a streaming video clipping core. A host writes a run enable and four 16-bit clipping bounds through a byte-enabled register port. Those writes land in staging registers. The staged values are copied into shadow registers only at a frame boundary, so the datapath always sees one consistent set of settings for a whole frame, whatever the host does during that frame.

The datapath asks to begin a frame with `frame_req`. When the sequencer is idle, it copies the staged settings into the shadow bank and then decides. If the captured enable is 1, it pulses `frame_grant` and holds the busy state until `frame_done`. If the enable is 0, it goes back to idle without a grant, so processing stops cleanly at the boundary and never part way through a frame. The busy state is the only readable register.

The sequencer states are ST_IDLE, ST_DECIDE and ST_ACTIVE. Its transitions are:
- ST_IDLE to ST_DECIDE on `frame_req`, capturing the shadow copy.
- ST_DECIDE to ST_ACTIVE when the captured enable is 1, with a grant.
- ST_DECIDE to ST_IDLE when the captured enable is 0, with no grant.
- ST_ACTIVE to ST_IDLE on `frame_done`.

Top module: `clip_ctrl_regs`

## Requirements
- R1: The shadow copy (`clip_bounds` and the captured enable) changes only at the clock edge that takes the sequencer from ST_IDLE to ST_DECIDE on `frame_req`. Host writes made at any other time leave `clip_bounds` unchanged.
- R2: The run enable is bit 0 at address 0, written through byte lane 0. The other bits at that address have no effect.
- R3: If the enable captured at a boundary is 0, no grant is given and the busy state stays 0. While busy, clearing the enable does not end the current frame.
- R4: Address 1 bit 0 reads 1 from the cycle after a grant until the cycle after `frame_done`, and reads 0 otherwise.
- R5: Address 1 is the only readable address. A read of any other address returns zero.
- R6: On a write, `host_be[k]` gates byte lane k (bits 8k+7:8k). Lanes whose enable is 0 keep their old value. Lanes above a register's width are ignored.
- R7: Reads have no side effects, and `host_be` is ignored on reads.
- R8: `host_rdata` and `host_rvalid` appear one cycle after `host_rd`, and `host_rvalid` is high for exactly one cycle per read.
- R9: `host_wait` is always 0.
- R10: The clip bounds are at addresses 2 (left), 3 (right), 4 (top) and 5 (bottom), each 16 bits wide. In `clip_bounds`, left sits in bits 15:0, right in 31:16, top in 47:32 and bottom in 63:48.
- R11: A `frame_req` sampled in ST_IDLE gives a one-cycle `frame_grant` on the following cycle when the captured enable is 1. The sequencer then enters ST_ACTIVE.
- R12: After reset, the enable, the busy state, all staging registers and all shadow registers are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| host_addr | input | 3 | Word address |
| host_wr | input | 1 | Write strobe |
| host_wdata | input | 32 | Write data |
| host_be | input | 4 | Byte lane enables for writes |
| host_rd | input | 1 | Read strobe |
| host_rdata | output | 32 | Read data |
| host_rvalid | output | 1 | Read data valid, one cycle |
| host_wait | output | 1 | Stall request, always low |
| frame_req | input | 1 | Datapath asks to start a frame |
| frame_grant | output | 1 | Frame start granted |
| frame_done | input | 1 | Datapath has finished the frame |
| clip_bounds | output | 64 | Shadowed clip bounds {bottom, top, right, left} |

## Verification
The assertions assume two things about the datapath: it raises `frame_done` only while a frame is in progress, and it does not expect a grant while the sequencer is in ST_DECIDE. The stimulus respects both. It pulses `frame_req` for one cycle only when no frame is running, and pulses `frame_done` only after a grant. It also issues one host access per cycle, so no read overlaps the read data of another read.

// File: rtl/clip_ctrl_pkg.sv
package clip_ctrl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_DECIDE = 2'd1,
        ST_ACTIVE = 2'd2
    } seq_state_t;

    localparam int ADDR_RUN    = 0;
    localparam int ADDR_BUSY   = 1;
    localparam int ADDR_BOUND0 = 2;

endpackage

// File: rtl/cfg_staging.sv
module cfg_staging #(
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 3,
    parameter int PARAM_W    = 16,
    parameter int NUM_PARAMS = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr,
    input  logic [ADDR_W-1:0]             addr,
    input  logic [DATA_W-1:0]             wdata,
    input  logic [DATA_W/8-1:0]           be,
    output logic                          stage_run,
    output logic [NUM_PARAMS*PARAM_W-1:0] stage_params
);
    import clip_ctrl_pkg::*;

    localparam int LANES = PARAM_W / 8;

    // Only the low lanes are used; the rest are ignored by design (R6).
    logic unused_ok;
    assign unused_ok = ^{wdata[DATA_W-1:PARAM_W], be[DATA_W/8-1:LANES]};

    // Run enable: bit 0, lane 0 (R2).
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            stage_run <= 1'b0;
        else if (wr && addr == ADDR_W'(ADDR_RUN) && be[0])
            stage_run <= wdata[0];
    end

    for (genvar p = 0; p < NUM_PARAMS; p++) begin : g_param
        for (genvar b = 0; b < LANES; b++) begin : g_lane
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    stage_params[p*PARAM_W + b*8 +: 8] <= '0;
                else if (wr && addr == ADDR_W'(ADDR_BOUND0 + p) && be[b])
                    stage_params[p*PARAM_W + b*8 +: 8] <= wdata[b*8 +: 8];
            end
        end
    end

    // Staging holds still when the host is not writing (R6).
    assert_staging_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> ($stable(stage_params) && $stable(stage_run)));

endmodule

// File: rtl/shadow_bank.sv
module shadow_bank #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         latch,
    input  logic         d_run,
    input  logic [W-1:0] d_params,
    output logic         q_run,
    output logic [W-1:0] q_params
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_run    <= 1'b0;
            q_params <= '0;
        end else if (latch) begin
            q_run    <= d_run;
            q_params <= d_params;
        end
    end

    // Shadow only moves on a boundary capture (R1).
    assert_shadow_frozen_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !latch |=> ($stable(q_params) && $stable(q_run)));

endmodule

// File: rtl/frame_seq.sv
module frame_seq (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_req,
    input  logic frame_done,
    input  logic shadow_run,
    output logic latch,
    output logic frame_grant,
    output logic busy
);
    import clip_ctrl_pkg::*;

    seq_state_t state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (frame_req)  state_nx = ST_DECIDE;
            ST_DECIDE: state_nx = shadow_run ? ST_ACTIVE : ST_IDLE;
            ST_ACTIVE: if (frame_done) state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        latch       = 1'b0;
        frame_grant = 1'b0;
        busy        = 1'b0;
        unique case (state)
            ST_IDLE:   latch       = frame_req;
            ST_DECIDE: frame_grant = shadow_run;
            ST_ACTIVE: busy        = 1'b1;
            default:   ;
        endcase
    end

    // A frame in progress only ends on frame_done (R3).
    assert_no_midframe_stop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !frame_done) |=> busy);

    // A grant leads into the busy state (R11).
    assert_grant_to_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        frame_grant |=> (busy && !frame_grant));

endmodule

// File: rtl/read_port.sv
module read_port #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    input  logic              busy,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);
    import clip_ctrl_pkg::*;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else begin
            rvalid <= rd;
            if (rd)
                rdata <= (addr == ADDR_W'(ADDR_BUSY)) ? DATA_W'(busy) : '0;
        end
    end

    // One valid per read, one cycle later (R8).
    assert_rvalid_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd |=> rvalid);
    assert_rvalid_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> !rvalid);

    // Write-only addresses read as zero (R5).
    assert_wo_reads_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && addr != ADDR_W'(ADDR_BUSY)) |=> (rdata == '0));

endmodule

// File: rtl/clip_ctrl_regs.sv
module clip_ctrl_regs #(
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 3,
    parameter int PARAM_W    = 16,
    parameter int NUM_PARAMS = 4,
    localparam int BE_W      = DATA_W / 8,
    localparam int BOUNDS_W  = NUM_PARAMS * PARAM_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   host_addr,
    input  logic                host_wr,
    input  logic [DATA_W-1:0]   host_wdata,
    input  logic [BE_W-1:0]     host_be,
    input  logic                host_rd,
    output logic [DATA_W-1:0]   host_rdata,
    output logic                host_rvalid,
    output logic                host_wait,
    input  logic                frame_req,
    output logic                frame_grant,
    input  logic                frame_done,
    output logic [BOUNDS_W-1:0] clip_bounds
);
    logic                stage_run, shadow_run, latch, busy;
    logic [BOUNDS_W-1:0] stage_params;

    assign host_wait = 1'b0;

    cfg_staging #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .PARAM_W(PARAM_W), .NUM_PARAMS(NUM_PARAMS)
    ) u_stage (
        .clk(clk), .rst_n(rst_n), .wr(host_wr), .addr(host_addr),
        .wdata(host_wdata), .be(host_be),
        .stage_run(stage_run), .stage_params(stage_params)
    );

    shadow_bank #(.W(BOUNDS_W)) u_shadow (
        .clk(clk), .rst_n(rst_n), .latch(latch),
        .d_run(stage_run), .d_params(stage_params),
        .q_run(shadow_run), .q_params(clip_bounds)
    );

    frame_seq u_seq (
        .clk(clk), .rst_n(rst_n), .frame_req(frame_req), .frame_done(frame_done),
        .shadow_run(shadow_run), .latch(latch),
        .frame_grant(frame_grant), .busy(busy)
    );

    read_port #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd (
        .clk(clk), .rst_n(rst_n), .rd(host_rd), .addr(host_addr), .busy(busy),
        .rdata(host_rdata), .rvalid(host_rvalid)
    );

    // Busy read value tracks the grant/done handshake (R4).
    assert_busy_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && frame_done) |=> !busy);

endmodule

// File: tb/tb_clip_ctrl_regs.sv
module tb_clip_ctrl_regs;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  host_addr = '0;
    logic        host_wr = 1'b0;
    logic [31:0] host_wdata = '0;
    logic [3:0]  host_be = '0;
    logic        host_rd = 1'b0;
    logic [31:0] host_rdata;
    logic        host_rvalid, host_wait;
    logic        frame_req = 1'b0, frame_done = 1'b0;
    logic        frame_grant;
    logic [63:0] clip_bounds;

    int vectors = 0, miscompares = 0;
    bit finished = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #10 clk = ~clk;

    clip_ctrl_regs dut (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
        .host_wdata(host_wdata), .host_be(host_be), .host_rd(host_rd),
        .host_rdata(host_rdata), .host_rvalid(host_rvalid), .host_wait(host_wait),
        .frame_req(frame_req), .frame_grant(frame_grant), .frame_done(frame_done),
        .clip_bounds(clip_bounds)
    );

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: pops expected read data as results appear (R8, R9).
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (host_wait !== 1'b0) begin
                miscompares++;
                $display("FAIL R9 actual=%0b expected=0", host_wait);
            end
            if (host_rvalid === 1'b1) begin
                if (exp_q.size() == 0) begin
                    vectors++; miscompares++;
                    $display("FAIL R8 actual=rvalid expected=idle");
                end else begin
                    string t;
                    logic [31:0] e;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(t, {32'b0, host_rdata}, {32'b0, e});
                end
            end
        end
    end

    task automatic do_write(input logic [2:0] a, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d; host_be = be;
        @(negedge clk);
        host_wr = 1'b0; host_be = '0;
    endtask

    task automatic do_read(input logic [2:0] a, input logic [3:0] be,
                           input logic [31:0] exp, input string req);
        @(negedge clk);
        exp_q.push_back(exp); tag_q.push_back(req);
        host_rd = 1'b1; host_addr = a; host_be = be;
        @(negedge clk);
        host_rd = 1'b0; host_be = '0;
    endtask

    // Request a frame; check the grant and the shadow copy in the decide cycle.
    task automatic start_frame(input logic exp_grant, input logic [63:0] exp_bounds, input string req);
        @(negedge clk);
        frame_req = 1'b1;
        @(negedge clk);
        frame_req = 1'b0;
        check(req, {63'b0, frame_grant}, {63'b0, exp_grant});
        check("R1", clip_bounds, exp_bounds);
        @(negedge clk);
        check("R11 single grant", {63'b0, frame_grant}, 64'd0);
    endtask

    task automatic end_frame;
        @(negedge clk);
        frame_done = 1'b1;
        @(negedge clk);
        frame_done = 1'b0;
    endtask

    localparam logic [63:0] B1 = 64'h0040_0030_0020_0010;
    localparam logic [63:0] B2 = 64'h0040_0030_0220_0010;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R12: reset state
        check("R12 bounds", clip_bounds, 64'd0);
        check("R12 grant", {63'b0, frame_grant}, 64'd0);
        do_read(3'd1, 4'hF, 32'd0, "R12 busy");

        // R10/R6: bounds with junk in the upper lanes
        do_write(3'd2, 32'hABCD_0010, 4'hF);
        do_write(3'd3, 32'hABCD_0020, 4'hF);
        do_write(3'd4, 32'h1234_0030, 4'hF);
        do_write(3'd5, 32'hFFFF_0040, 4'hF);
        check("R1 no early effect", clip_bounds, 64'd0);

        // R3: enable still 0 -> no grant, but the boundary captures bounds
        start_frame(1'b0, B1, "R3 no grant");
        do_read(3'd1, 4'hF, 32'd0, "R3 busy stays 0");

        // R2/R6: other bits and lanes do not set the enable
        do_write(3'd0, 32'hFFFF_FFFE, 4'hF);
        do_write(3'd0, 32'h0000_0001, 4'b1110);
        start_frame(1'b0, B1, "R2 enable untouched");

        do_write(3'd0, 32'h0000_0001, 4'b0001);
        start_frame(1'b1, B1, "R11 grant");
        do_read(3'd1, 4'hF, 32'd1, "R4 busy during frame");

        // R1/R6: mid-frame write to right bound, lane 1 only
        do_write(3'd3, 32'h0000_0200, 4'b0010);
        check("R1 mid-frame", clip_bounds, B1);
        do_read(3'd0, 4'hF, 32'd0, "R5 addr0");
        do_read(3'd3, 4'hF, 32'd0, "R5 addr3");
        do_read(3'd1, 4'h0, 32'd1, "R7 be ignored");
        do_read(3'd1, 4'h0, 32'd1, "R7 no side effect");

        // R3: clearing enable mid-frame keeps the frame running
        do_write(3'd0, 32'h0, 4'h1);
        do_read(3'd1, 4'hF, 32'd1, "R3 no midframe stop");
        end_frame();
        do_read(3'd1, 4'hF, 32'd0, "R4 busy after done");
        start_frame(1'b0, B2, "R3 stop at boundary");

        // R8: back-to-back reads, then rvalid must drop
        do_write(3'd0, 32'h1, 4'h1);
        start_frame(1'b1, B2, "R11 regrant");
        @(negedge clk);
        exp_q.push_back(32'd1); tag_q.push_back("R8 first");
        host_rd = 1'b1; host_addr = 3'd1;
        @(negedge clk);
        exp_q.push_back(32'd0); tag_q.push_back("R8 second");
        host_addr = 3'd4;
        @(negedge clk);
        host_rd = 1'b0;
        @(negedge clk);
        check("R8 rvalid drops", {63'b0, host_rvalid}, 64'd0);
        end_frame();
        repeat (2) @(negedge clk);
        check("R8 queue drained", 64'(exp_q.size()), 64'd0);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!finished) begin
            finished = 1'b1;
            vectors++; miscompares++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule